// File: doc/BRIEF.md
# Change-Only Logic Trace Recorder

The recorder watches a bank of sixteen digital channels on every cycle of the system clock and writes a memory record only when the channel pattern moves. Each record pairs the new pattern with the count of clock cycles since the record before it. Long idle stretches therefore cost almost no storage, and a pulse only one clock wide still leaves a trace. The block drives a plain synchronous write port: address, record word and a one-cycle write strobe. A behavioural array or an SRAM controller can sit behind that port.

Capture starts with an arm pulse and ends on a stop pulse or when the store is full. The channels pass through a two-stage synchroniser before they are compared. When the elapsed-cycle field is about to run out with no input activity, a filler record keeps the time base continuous. Summing the elapsed fields from address zero gives the absolute time of every transition.

Top module: `edge_trace_capture`

## Requirements
- R1: While reset is held and after it is released, wr_en, busy and done are low and rec_count is zero.
- R2: An arm pulse clears the record count, lowers done and raises busy. The first record after arm goes to address 0 and holds the synchronised pattern with an elapsed field of zero.
- R3: A record is written only on a cycle where the synchronised pattern differs from the last recorded one. The pattern sits in the upper CH_W bits of wr_data and the elapsed field in the lower DELTA_W bits. The elapsed field is the number of clock cycles since the previous record.
- R4: A pattern change lasting one sample produces two records: the entry record, and an exit record whose elapsed field is 1.
- R5: When the elapsed count has reached all ones and the pattern is unchanged, a filler record holds the unchanged pattern and an all-ones elapsed field. The next record then counts from 1 again.
- R6: When a pattern change falls on the same cycle as an all-ones elapsed count, exactly one record is written: the new pattern with an all-ones elapsed field, and no filler.
- R7: Records go to consecutive addresses starting at 0, with wr_en high for exactly one clock per record.
- R8: After 2**ADDR_W records, capture ends: busy falls, done rises, rec_count equals 2**ADDR_W and no further writes occur.
- R9: A stop pulse during capture ends it. busy falls, done rises, and rec_count holds the number of records written.
- R10: Input changes while the block is idle or done cause no write and leave rec_count unchanged.
- R11: Arming again after done restarts at address 0 with rec_count cleared and done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, channels sampled every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle pulse that starts a fresh capture |
| stop | input | 1 | One-cycle pulse that ends a running capture |
| ch_in | input | CH_W (16) | Asynchronous channel inputs |
| wr_en | output | 1 | Record write strobe, one cycle per record |
| wr_addr | output | ADDR_W (18) | Record address |
| wr_data | output | CH_W+DELTA_W (32) | Record: pattern in upper bits, elapsed cycles in lower bits |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Capture ended by stop or full store |
| rec_count | output | ADDR_W+1 (19) | Records written in the current or last capture |

## Verification
Two functions can fall in the same cycle: a pattern change, and the overflow of the elapsed counter that would otherwise emit a filler. The bench holds one pattern for one cycle short of the counter limit, then changes the input exactly when the count reaches all ones. It judges the result from the record stream: one record carrying the new pattern and an all-ones elapsed field, with no filler before it. A scoreboard built from a cycle-level model of the requirements compares every address and record in order, so a stray filler or a missing record shows up as a mismatch.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_state_e;
endpackage

// File: rtl/trc_sync.sv
module trc_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= '0;
        else        stg_q[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= '0;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/trc_delta.sv
module trc_delta #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          zero,
  input  logic          restart,
  output logic [DW-1:0] elapsed,
  output logic          at_max
);
  logic [DW-1:0] cnt_q, cnt_d;

  assign at_max  = &cnt_q;
  assign elapsed = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (zero)                 cnt_d = '0;
    else if (restart)         cnt_d = DW'(1);
    else if (en && !at_max)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int CH_W    = 16,
  parameter int DELTA_W = 16,
  parameter int ADDR_W  = 18,
  localparam int RW     = CH_W + DELTA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              stop,
  input  logic [CH_W-1:0]   samp,
  input  logic [DELTA_W-1:0] elapsed,
  input  logic              elapsed_max,
  output logic              rec_take,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [RW-1:0]     wr_data,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W:0]   rec_count
);
  localparam int              DEPTH    = 1 << ADDR_W;
  localparam logic [ADDR_W:0] LAST_IDX = (ADDR_W+1)'(DEPTH - 1);

  run_state_e          st_q, st_d;
  logic                first_q, first_d;
  logic [CH_W-1:0]     last_q, last_d;
  logic [ADDR_W:0]     cnt_q, cnt_d;
  logic                wr_en_q;
  logic [ADDR_W-1:0]   wr_addr_q;
  logic [RW-1:0]       wr_data_q, rec_word;
  logic                rec;

  always_comb begin
    st_d     = st_q;
    first_d  = first_q;
    last_d   = last_q;
    cnt_d    = cnt_q;
    rec      = 1'b0;
    rec_word = {samp, elapsed};
    if (arm) begin
      st_d    = ST_RUN;
      first_d = 1'b1;
      cnt_d   = '0;
    end else if (st_q == ST_RUN) begin
      if (stop) begin
        st_d = ST_DONE;
      end else begin
        if (first_q) begin
          rec      = 1'b1;
          rec_word = {samp, {DELTA_W{1'b0}}};
        end else if (samp != last_q) begin
          rec = 1'b1;
        end else if (elapsed_max) begin
          rec      = 1'b1;
          rec_word = {last_q, elapsed};
        end
        if (rec) begin
          first_d = 1'b0;
          last_d  = samp;
          cnt_d   = cnt_q + 1'b1;
          if (cnt_q == LAST_IDX) st_d = ST_DONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      first_q <= 1'b0;
      last_q  <= '0;
      cnt_q   <= '0;
      wr_en_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= first_d;
      last_q  <= last_d;
      cnt_q   <= cnt_d;
      wr_en_q <= rec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (rec) begin
      wr_addr_q <= cnt_q[ADDR_W-1:0];
      wr_data_q <= rec_word;
    end
  end

  assign rec_take  = rec;
  assign wr_en     = wr_en_q;
  assign wr_addr   = wr_addr_q;
  assign wr_data   = wr_data_q;
  assign busy      = (st_q == ST_RUN);
  assign done      = (st_q == ST_DONE);
  assign rec_count = cnt_q;
endmodule

// File: rtl/edge_trace_capture.sv
module edge_trace_capture #(
  parameter int CH_W    = 16,
  parameter int DELTA_W = 16,
  parameter int ADDR_W  = 18,
  localparam int RW     = CH_W + DELTA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              stop,
  input  logic [CH_W-1:0]   ch_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [RW-1:0]     wr_data,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W:0]   rec_count
);
  logic [CH_W-1:0]    samp;
  logic [DELTA_W-1:0] elapsed;
  logic               elapsed_max;
  logic               rec_take;

  trc_sync #(.W(CH_W), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ch_in),
    .q     (samp)
  );

  trc_delta #(.DW(DELTA_W)) u_delta (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (busy),
    .zero    (arm),
    .restart (rec_take),
    .elapsed (elapsed),
    .at_max  (elapsed_max)
  );

  trc_ctrl #(.CH_W(CH_W), .DELTA_W(DELTA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (arm),
    .stop        (stop),
    .samp        (samp),
    .elapsed     (elapsed),
    .elapsed_max (elapsed_max),
    .rec_take    (rec_take),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .busy        (busy),
    .done        (done),
    .rec_count   (rec_count)
  );
endmodule

// File: rtl/edge_trace_capture_chk.sv
module edge_trace_capture_chk #(
  parameter int CH_W    = 16,
  parameter int DELTA_W = 16,
  parameter int ADDR_W  = 18
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         wr_addr,
  input logic [CH_W+DELTA_W-1:0]   wr_data,
  input logic                      busy,
  input logic                      done,
  input logic [ADDR_W:0]           rec_count
);
  localparam logic [ADDR_W:0] FULL_N = (ADDR_W+1)'(1 << ADDR_W);

  AST_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(busy)); // R10

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1)); // R7

  AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0) |-> (wr_data[DELTA_W-1:0] == '0)); // R2

  AST_LATER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0) |-> (wr_data[DELTA_W-1:0] != '0)); // R3

  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9

  AST_FULL_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_count == FULL_N) |=> !wr_en); // R8
endmodule

bind edge_trace_capture edge_trace_capture_chk #(
  .CH_W(CH_W), .DELTA_W(DELTA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .busy      (busy),
  .done      (done),
  .rec_count (rec_count)
);

// File: tb/edge_trace_capture_bench.sv
module edge_trace_capture_bench;
  localparam int CH   = 16;
  localparam int DW   = 6;
  localparam int AW   = 5;
  localparam int RW   = CH + DW;
  localparam int DEP  = 1 << AW;
  localparam int MAXD = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm = 1'b0;
  logic          stop = 1'b0;
  logic [CH-1:0] ch_in = '0;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [RW-1:0] wr_data;
  logic          busy, done;
  logic [AW:0]   rec_count;

  always #2 clk = ~clk;

  edge_trace_capture #(.CH_W(CH), .DELTA_W(DW), .ADDR_W(AW)) u_edge_trace_capture (
    .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .ch_in(ch_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rec_count(rec_count)
  );

  int total = 0;
  int bad   = 0;
  logic [AW+RW-1:0] exp_q [$];

  // reference model state
  bit            m_on = 1'b0;
  logic [CH-1:0] m_last;
  int            m_el;
  int            nrec;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_rec(input logic [CH-1:0] p, input int el);
    exp_q.push_back({AW'(nrec), p, DW'(el)});
    nrec++;
  endtask

  task automatic model_step(input logic [CH-1:0] p);
    if (!m_on || nrec >= DEP) return;
    if (p != m_last) begin
      push_rec(p, m_el); m_last = p; m_el = 1;
    end else if (m_el == MAXD) begin
      push_rec(p, m_el); m_el = 1;
    end else begin
      m_el++;
    end
  endtask

  task automatic drive(input logic [CH-1:0] p, input int n);
    for (int i = 0; i < n; i++) begin
      ch_in = p;
      model_step(p);
      @(negedge clk);
    end
  endtask

  // ch_in must already be steady for two cycles
  task automatic do_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    m_on = 1'b1; nrec = 0;
    push_rec(ch_in, 0);
    m_last = ch_in; m_el = 2;
  endtask

  task automatic do_stop();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    m_on = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R10 unexpected write actual=%0h expected=none", {wr_addr, wr_data});
      end else begin
        logic [AW+RW-1:0] e;
        e = exp_q.pop_front();
        chk({wr_addr, wr_data} === e, "R3 R7 record", {wr_addr, wr_data}, e);
      end
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [AW:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!wr_en && !busy && !done && rec_count == 0, "R1 during reset", {wr_en, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_en && !busy && !done && rec_count == 0, "R1 after reset", {wr_en, busy, done}, 0);

    // R2 arm and first record
    drive(16'h1234, 3);
    do_arm();
    chk(busy && !done && rec_count == 0, "R2 arm state", {busy, done, rec_count}, 3'b100);

    // R3 plain changes, R4 one-sample glitch
    drive(16'h1234, 4);
    drive(16'h00FF, 3);
    drive(16'h80FF, 1);
    drive(16'h00FF, 5);
    // R5 long idle produces fillers
    drive(16'h00FF, 140);
    // R6 change lands exactly on an all-ones elapsed count
    drive(16'h5A5A, 1);
    drive(16'h5A5A, MAXD - 1);
    drive(16'hA5A5, 1);
    drive(16'hA5A5, 3);
    do_stop();
    drain("R6 queue drained");
    chk(done && !busy, "R9 stop state", {done, busy}, 2'b10);
    chk(rec_count == nrec, "R9 record count", rec_count, nrec);

    // R10 no writes while done
    held = rec_count;
    for (int i = 0; i < 10; i++) begin
      ch_in = 16'h0F00 ^ CH'(i * 7);
      @(negedge clk);
    end
    drain("R10 queue empty");
    chk(rec_count == held, "R10 count unchanged", rec_count, held);

    // R11 re-arm, then R8 fill the store
    drive(16'h7777, 3);
    do_arm();
    chk(!done && busy && rec_count == 0, "R11 rearm state", {done, busy, rec_count}, 3'b010);
    for (int i = 0; i < 40; i++) drive(16'hA000 + CH'(i), 1);
    drain("R8 queue drained");
    chk(done && !busy, "R8 full state", {done, busy}, 2'b10);
    chk(rec_count == DEP, "R8 full count", rec_count, DEP);
    for (int i = 0; i < 6; i++) begin
      ch_in = CH'(i * 3);
      @(negedge clk);
    end
    chk(rec_count == DEP, "R8 no writes after full", rec_count, DEP);
    finish_run();
  end
endmodule